// File: doc/BRIEF.md
# Fractional-Rate Time-Base Counter

This block keeps a 64-bit free-running time base that advances at a fixed nominal rate (6.144 MHz in the intended use), whatever the frequency of the reference clock that drives it. Each reference clock adds a programmable numerator to a fractional accumulator that wraps modulo a programmable denominator. Every wrap advances the counter by one. The long-run count rate is therefore exactly the reference frequency times numerator over denominator.

Software sets the ratio through a small word-addressed register port. The numerator register sits at offset 0x10 and the denominator register at offset 0x14. Only the low 12 bits of each register form the ratio. The remaining 20 bits are kept and read back so that read-modify-write sequences work, but they do not affect the count. The counter output is shared by the per-CPU local timers.

The ratios for common references are as follows. For 38.4 MHz use 4/25, which is also the reset default. For 27 MHz use 256/1125, for 26 MHz 384/1625, for 19.2 MHz 8/25, for 13 MHz 768/1625, and for 12 MHz 64/125.

Top module: `frac_timebase`

## Requirements
- R1: While reset is held, the count output is 0, the numerator register (0x10) reads 4 and the denominator register (0x14) reads 25.
- R2: With no write in between, the count advances by exactly N×num over any N×den reference clocks that start right after a ratio write, for each of the ratios 4/25, 8/25, 64/125, 768/1625, 384/1625 and 256/1125.
- R3: A write with address 0x10 stores all 32 bits into the numerator register, and a write with address 0x14 stores all 32 bits into the denominator register. Both read back in full on rd_data, but only bits [11:0] set the ratio.
- R4: The clock edge that captures a ratio write clears the accumulator and produces no increment. The new ratio applies from the next clock, so with 8/25 the count is unchanged 3 clocks after the write and has risen by 1 after 4 clocks, whatever remainder was left before the write.
- R5: The count never rises by more than one per reference clock.
- R6: A denominator field (bits [11:0]) of zero makes the block count at the 4/25 ratio, while the register still reads back the written value.
- R7: If the numerator field is greater than or equal to the non-zero denominator field, the count rises by one on every clock that carries no write.
- R8: A write to any address other than 0x10 or 0x14 changes neither register nor the count rate, and reading such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 8 | Byte address for both the write and the read |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| count | output | 64 | Free-running time-base count |

## Verification
The rate is measured over whole accumulator periods for six ratios that range from small (4/25) to large, nearly co-prime denominators (768/1625). This separates an exact modulo accumulator from one that truncates or drops the remainder. Short windows of three and four clocks after a write pin the cycle in which the new ratio applies. Rewriting the same ratio when the remainder is non-zero shows whether the accumulator is really cleared. Writing upper-bit garbage, a zero denominator field, a numerator above the denominator, and an unused address checks that only the ratio field counts and that each fallback path behaves as specified.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam logic [7:0] OFS_NUM = 8'h10;
  localparam logic [7:0] OFS_DEN = 8'h14;
  localparam int unsigned DEF_NUM = 4;
  localparam int unsigned DEF_DEN = 25;
endpackage

// File: rtl/frt_ratio_regs.sv
module frt_ratio_regs
  import frt_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int REG_W   = 32,
  parameter int RATIO_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  output logic [RATIO_W-1:0] num_eff,
  output logic [RATIO_W-1:0] den_eff,
  output logic               ratio_wr
);
  logic [REG_W-1:0] num_q, num_d, den_q, den_d;
  logic             sel_num, sel_den;
  logic [RATIO_W-1:0] den_fld;

  assign sel_num  = wr_en && (addr == ADDR_W'(OFS_NUM));
  assign sel_den  = wr_en && (addr == ADDR_W'(OFS_DEN));
  assign ratio_wr = sel_num || sel_den;

  always_comb begin
    num_d = num_q;
    den_d = den_q;
    if (sel_num) num_d = wr_data;
    if (sel_den) den_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q <= REG_W'(DEF_NUM);
      den_q <= REG_W'(DEF_DEN);
    end else if (ratio_wr) begin
      num_q <= num_d;
      den_q <= den_d;
    end
  end

  // A zero denominator field falls back to the reset ratio.
  assign den_fld = den_q[RATIO_W-1:0];
  always_comb begin
    if (den_fld == '0) begin
      num_eff = RATIO_W'(DEF_NUM);
      den_eff = RATIO_W'(DEF_DEN);
    end else begin
      num_eff = num_q[RATIO_W-1:0];
      den_eff = den_fld;
    end
  end

  always_comb begin
    if (addr == ADDR_W'(OFS_NUM))      rd_data = num_q;
    else if (addr == ADDR_W'(OFS_DEN)) rd_data = den_q;
    else                               rd_data = '0;
  end

  // R3
  num_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_num |=> (num_q == $past(wr_data)));
  // R3
  den_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_den |=> (den_q == $past(wr_data)));
endmodule

// File: rtl/frt_frac_accum.sv
module frt_frac_accum #(
  parameter int RATIO_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [RATIO_W-1:0] num,
  input  logic [RATIO_W-1:0] den,
  output logic               tick
);
  logic [RATIO_W-1:0] acc_q, acc_d;
  logic [RATIO_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, num};

  always_comb begin
    acc_d = acc_q;
    tick  = 1'b0;
    if (clr) begin
      acc_d = '0;
    end else if (num >= den) begin
      tick  = 1'b1;
      acc_d = '0;
    end else if (sum >= {1'b0, den}) begin
      tick  = 1'b1;
      acc_d = RATIO_W'(sum - {1'b0, den});
    end else begin
      acc_d = sum[RATIO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R4
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));
  // R2
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < den);
endmodule

// File: rtl/frt_tick_counter.sv
module frt_tick_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign cnt_d = cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R5
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1))));
endmodule

// File: rtl/frac_timebase.sv
module frac_timebase #(
  parameter int ADDR_W  = 8,
  parameter int REG_W   = 32,
  parameter int RATIO_W = 12,
  parameter int CNT_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic [CNT_W-1:0]  count
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [RATIO_W-1:0] num_eff, den_eff;
  logic               ratio_wr, tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  frt_ratio_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W), .RATIO_W(RATIO_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .num_eff(num_eff),
    .den_eff(den_eff), .ratio_wr(ratio_wr)
  );

  frt_frac_accum #(.RATIO_W(RATIO_W)) u_accum (
    .clk(clk), .rst_n(rst_int_n), .clr(ratio_wr),
    .num(num_eff), .den(den_eff), .tick(tick)
  );

  frt_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .count(count)
  );

  // R4
  hold_on_write_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ratio_wr |=> (count == $past(count)));
  // R7
  sat_rate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((num_eff >= den_eff) && !ratio_wr) |=> (count == $past(count) + CNT_W'(1)));
endmodule

// File: tb/frac_timebase_tb.sv
module frac_timebase_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [63:0] count;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    string           tag;
    longint unsigned start;
    longint unsigned exp;
  } item_t;
  item_t exp_q[$];
  event  meas_ev;

  always #4 clk = ~clk;

  frac_timebase u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .count(count)
  );

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 8'h00;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, longint'(rd_data), longint'(exp));
    addr = 8'h00;
  endtask

  task automatic measure(input string tag, input int cycles, input longint unsigned exp);
    item_t it;
    it.tag = tag; it.start = count; it.exp = exp;
    exp_q.push_back(it);
    repeat (cycles) @(negedge clk);
    ->meas_ev;
    #1;
  endtask

  task automatic run_ratio(input string tag, input int n, input int d, input int reps);
    wr(8'h10, 32'(n));
    wr(8'h14, 32'(d));
    measure(tag, reps * d, longint'(reps * n));
  endtask

  // monitor
  initial begin
    forever begin
      @(meas_ev);
      if (exp_q.size() != 0) begin
        item_t it;
        it = exp_q.pop_front();
        chk(it.tag, count - it.start, it.exp);
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = 8'h00; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 count in reset", count, 0);
    rd_chk("R1 num reset", 8'h10, 32'd4);
    rd_chk("R1 den reset", 8'h14, 32'd25);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 listed ratios
    run_ratio("R2 4/25",      4,   25, 3);
    run_ratio("R2 8/25",      8,   25, 4);
    run_ratio("R2 64/125",    64,  125, 2);
    run_ratio("R2 768/1625",  768, 1625, 2);
    run_ratio("R2 384/1625",  384, 1625, 2);
    run_ratio("R2 256/1125",  256, 1125, 2);

    // R3 upper bits kept, ignored for rate
    wr(8'h10, 32'hABCDE040);
    wr(8'h14, 32'h1234507D);
    rd_chk("R3 num readback", 8'h10, 32'hABCDE040);
    rd_chk("R3 den readback", 8'h14, 32'h1234507D);
    wr(8'h14, 32'h1234507D);
    measure("R3 rate 64/125 with upper bits", 250, 128);

    // R4 timing after write
    wr(8'h10, 32'd8);
    wr(8'h14, 32'd25);
    measure("R4 three clocks after write", 3, 0);
    measure("R4 fourth clock", 1, 1);
    // leave remainder 10 (20 clocks of 8/25 from a cleared state)
    wr(8'h10, 32'd8);
    repeat (20) @(negedge clk);
    wr(8'h10, 32'd8);
    measure("R4 remainder cleared, two clocks", 2, 0);
    measure("R4 remainder cleared, two more", 2, 1);

    // R6 zero denominator field
    wr(8'h14, 32'h00007000);
    rd_chk("R6 den readback", 8'h14, 32'h00007000);
    wr(8'h10, 32'd100);
    measure("R6 fallback 4/25", 50, 8);

    // R7 numerator >= denominator, also R5 at most one per clock
    wr(8'h10, 32'd30);
    wr(8'h14, 32'd25);
    measure("R5 R7 saturated rate", 40, 40);

    // R8 unused address
    wr(8'h10, 32'd8);
    wr(8'h14, 32'd25);
    wr(8'h18, 32'h00000FFF);
    rd_chk("R8 num unchanged", 8'h10, 32'd8);
    rd_chk("R8 den unchanged", 8'h14, 32'd25);
    rd_chk("R8 unused reads zero", 8'h18, 32'd0);
    measure("R8 rate unchanged", 50, 16);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule